// File: doc/BRIEF.md
# Planar Video Write Datapath

This block turns a single CPU byte write into four bytes, one for each bit plane of a planar display memory, together with a write strobe for each plane. A small indexed register file holds the controls: a per-plane colour, a per-plane colour-substitution enable, a rotate count with a logic-function select, a write-mode select and a bit mask. Software first writes an index through the index port. It then writes or reads the selected register through the data port.

On each CPU write, the datapath combines the CPU byte, the four latch bytes captured by an earlier read, and the control registers. The combination follows one of four write modes. The plane bytes and strobes are combinational from the inputs and the stored controls. Memory arrays, address decoding and scan-out stay outside the block.

Top module: `planar_write_path`

## Requirements
- R1: A write with `cfg_sel`=0 stores the low 4 bits of `cfg_wdata` as the index. A read with `cfg_sel`=0 returns that index, zero-extended.
- R2: With `cfg_sel`=1, a write stores `cfg_wdata` into the register the index selects, and a read returns the stored value. Index 0 is plane colour and keeps 4 bits. Index 1 is colour enable and keeps 4 bits. Index 3 is rotate/function, index 5 is mode and index 8 is bit mask; these three keep all 8 bits.
- R3: Any index other than 0, 1, 3, 5 or 8 reads as zero, and a data-port write to it changes no register.
- R4: `plane_we[p]` equals `plane_en[p]` AND `cpu_we`.
- R5: When mode bits 1:0 equal 1, plane byte p equals latch byte p.
- R6: When mode bits 1:0 equal 0, the CPU byte is rotated right by rotate/function bits 2:0. A plane whose colour-enable bit is 1 uses eight copies of its colour bit in place of the rotated byte.
- R7: In modes 0 and 2, rotate/function bits 4:3 combine the source byte with the latch byte before masking: 0 passes it, 1 ANDs it, 2 ORs it and 3 XORs it.
- R8: When mode bits 1:0 equal 2, the source byte for plane p is eight copies of CPU data bit p.
- R9: When mode bits 1:0 equal 3, the rotated CPU byte is ANDed with the bit mask. Each set bit of the result takes the plane's colour bit, and each clear bit takes the latch bit.
- R10: In modes 0 and 2, a bit-mask bit of 1 passes the combined value and a bit-mask bit of 0 keeps the latch bit.
- R11: After reset, the index and all registers read zero, and every plane byte equals its latch byte.
- Plane p occupies bits 8p+7 to 8p of `latch_in` and of `plane_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register-port write strobe |
| cfg_sel | input | 1 | 0 = index port, 1 = data port |
| cfg_wdata | input | 8 | Register-port write data |
| cfg_rdata | output | 8 | Register-port read data |
| cpu_we | input | 1 | CPU display-memory write strobe |
| cpu_data | input | 8 | CPU write byte |
| latch_in | input | 32 | Four latch bytes |
| plane_en | input | 4 | Per-plane write enable |
| plane_data | output | 32 | Four plane bytes to memory |
| plane_we | output | 4 | Per-plane write strobes |

## Verification
The hardest case to reach is a plane byte in which every control acts on it at once. That means a non-zero rotate together with colour substitution on some planes only, a non-pass logic function and a partial bit mask. All of these sit behind separate indexed writes, and each one needs an index write followed by a data write. The bench therefore writes random values to random registers between random CPU writes. Over time this builds up mixed settings that cover all four modes. Directed sequences add the reset state, index truncation, writes to unused indices, and a fixed mask case for each logic function.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int IX_COLOR    = 0;
  localparam int IX_COLOR_EN = 1;
  localparam int IX_ROTFN    = 3;
  localparam int IX_MODE     = 5;
  localparam int IX_MASK     = 8;

  typedef enum logic [1:0] {
    WM_ALU     = 2'd0,
    WM_COPY    = 2'd1,
    WM_FILL    = 2'd2,
    WM_PATTERN = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_AND  = 2'd1,
    FN_OR   = 2'd2,
    FN_XOR  = 2'd3
  } lfn_e;
endpackage

// File: rtl/pw_ctrl_regs.sv
module pw_ctrl_regs #(
  parameter int DATA_W = 8,
  parameter int PLANES = 4,
  parameter int IDX_W  = 4,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PLANES-1:0] color,
  output logic [PLANES-1:0] color_en,
  output logic [ROT_W-1:0]  rot_amt,
  output logic [1:0]        fn_sel,
  output logic [1:0]        mode_sel,
  output logic [DATA_W-1:0] bmask
);
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PLANES-1:0] col_q, col_d, cen_q, cen_d;
  logic [DATA_W-1:0] rfn_q, rfn_d, mod_q, mod_d, msk_q, msk_d;
  logic              idx_ok;

  always_comb begin
    idx_ok = 1'b0;
    case (idx_q)
      IDX_W'(pw_pkg::IX_COLOR), IDX_W'(pw_pkg::IX_COLOR_EN),
      IDX_W'(pw_pkg::IX_ROTFN), IDX_W'(pw_pkg::IX_MODE),
      IDX_W'(pw_pkg::IX_MASK): idx_ok = 1'b1;
      default: idx_ok = 1'b0;
    endcase
  end

  always_comb begin
    idx_d = idx_q;
    col_d = col_q;
    cen_d = cen_q;
    rfn_d = rfn_q;
    mod_d = mod_q;
    msk_d = msk_q;
    if (wr && !sel) idx_d = wdata[IDX_W-1:0];
    if (wr && sel) begin
      case (idx_q)
        IDX_W'(pw_pkg::IX_COLOR):    col_d = wdata[PLANES-1:0];
        IDX_W'(pw_pkg::IX_COLOR_EN): cen_d = wdata[PLANES-1:0];
        IDX_W'(pw_pkg::IX_ROTFN):    rfn_d = wdata;
        IDX_W'(pw_pkg::IX_MODE):     mod_d = wdata;
        IDX_W'(pw_pkg::IX_MASK):     msk_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      col_q <= '0;
      cen_q <= '0;
      rfn_q <= '0;
      mod_q <= '0;
      msk_q <= '0;
    end else begin
      idx_q <= idx_d;
      col_q <= col_d;
      cen_q <= cen_d;
      rfn_q <= rfn_d;
      mod_q <= mod_d;
      msk_q <= msk_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (!sel) begin
      rdata = {{(DATA_W-IDX_W){1'b0}}, idx_q};
    end else begin
      case (idx_q)
        IDX_W'(pw_pkg::IX_COLOR):    rdata = {{(DATA_W-PLANES){1'b0}}, col_q};
        IDX_W'(pw_pkg::IX_COLOR_EN): rdata = {{(DATA_W-PLANES){1'b0}}, cen_q};
        IDX_W'(pw_pkg::IX_ROTFN):    rdata = rfn_q;
        IDX_W'(pw_pkg::IX_MODE):     rdata = mod_q;
        IDX_W'(pw_pkg::IX_MASK):     rdata = msk_q;
        default:                     rdata = '0;
      endcase
    end
  end

  assign color    = col_q;
  assign color_en = cen_q;
  assign rot_amt  = rfn_q[ROT_W-1:0];
  assign fn_sel   = rfn_q[ROT_W+1:ROT_W];
  assign mode_sel = mod_q[1:0];
  assign bmask    = msk_q;

  // R1: the index port keeps only its low bits
  p_index_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sel) |=> (idx_q == $past(wdata[IDX_W-1:0])));

  // R3: a data write to an unused index leaves every register as it was
  p_unused_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel && !idx_ok) |=> (col_q == $past(col_q) && cen_q == $past(cen_q) &&
      rfn_q == $past(rfn_q) && mod_q == $past(mod_q) && msk_q == $past(msk_q)));
endmodule

// File: rtl/pw_rotator.sv
module pw_rotator #(
  parameter int DATA_W = 8,
  localparam int ROT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [ROT_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [2*DATA_W-1:0] dbl;

  always_comb begin
    dbl  = {din, din} >> amt;
    dout = dbl[DATA_W-1:0];
  end
endmodule

// File: rtl/pw_plane_lane.sv
module pw_plane_lane #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pw_pkg::wmode_e    mode,
  input  pw_pkg::lfn_e      fn,
  input  logic              cpu_bit,
  input  logic [DATA_W-1:0] rot,
  input  logic [DATA_W-1:0] latch,
  input  logic [DATA_W-1:0] bmask,
  input  logic              col_bit,
  input  logic              col_en,
  output logic [DATA_W-1:0] dout
);
  import pw_pkg::*;

  logic [DATA_W-1:0] src, alu, pat;

  always_comb begin
    src = col_en ? {DATA_W{col_bit}} : rot;
    if (mode == WM_FILL) src = {DATA_W{cpu_bit}};
    case (fn)
      FN_AND:  alu = src & latch;
      FN_OR:   alu = src | latch;
      FN_XOR:  alu = src ^ latch;
      default: alu = src;
    endcase
    pat = rot & bmask;
    case (mode)
      WM_COPY:    dout = latch;
      WM_PATTERN: dout = (pat & {DATA_W{col_bit}}) | (latch & ~pat);
      default:    dout = (alu & bmask) | (latch & ~bmask);
    endcase
  end

  // R5: copy mode passes the latch unchanged
  p_copy_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_COPY) |-> (dout == latch));

  // R10: masked-off positions hold the latch bit in modes 0 and 2
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_ALU || mode == WM_FILL) |-> (((dout ^ latch) & ~bmask) == '0));

  // R8: fill mode with pass function and full mask gives a replicated CPU bit
  p_fill_rep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_FILL && fn == FN_PASS && bmask == '1) |-> (dout == {DATA_W{cpu_bit}}));

  // R9: pattern mode changes only positions selected by rotated data and mask
  p_pattern_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_PATTERN) |-> (((dout ^ latch) & ~(rot & bmask)) == '0));
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path #(
  parameter int DATA_W = 8,
  parameter int PLANES = 4,
  parameter int IDX_W  = 4,
  localparam int ROT_W = $clog2(DATA_W),
  localparam int BUS_W = DATA_W * PLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic [BUS_W-1:0]  latch_in,
  input  logic [PLANES-1:0] plane_en,
  output logic [BUS_W-1:0]  plane_data,
  output logic [PLANES-1:0] plane_we
);
  logic [1:0]        rst_sync;
  logic              rst_s;
  logic [PLANES-1:0] color, color_en;
  logic [ROT_W-1:0]  rot_amt;
  logic [1:0]        fn_sel, mode_sel;
  logic [DATA_W-1:0] bmask, rot_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  pw_ctrl_regs #(.DATA_W(DATA_W), .PLANES(PLANES), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .color(color), .color_en(color_en), .rot_amt(rot_amt),
    .fn_sel(fn_sel), .mode_sel(mode_sel), .bmask(bmask)
  );

  pw_rotator #(.DATA_W(DATA_W)) u_rot (
    .din(cpu_data), .amt(rot_amt), .dout(rot_data)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_lane
    pw_plane_lane #(.DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst_n(rst_s),
      .mode(pw_pkg::wmode_e'(mode_sel)), .fn(pw_pkg::lfn_e'(fn_sel)),
      .cpu_bit(cpu_data[p]), .rot(rot_data),
      .latch(latch_in[p*DATA_W +: DATA_W]), .bmask(bmask),
      .col_bit(color[p]), .col_en(color_en[p]),
      .dout(plane_data[p*DATA_W +: DATA_W])
    );
  end

  always_comb plane_we = plane_en & {PLANES{cpu_we}};

  // R4: no strobe without a CPU write
  p_no_idle_strobe_r4: assert property (@(posedge clk) disable iff (!rst_s)
    !cpu_we |-> (plane_we == '0));

  // R4: a disabled plane is never strobed
  p_no_masked_strobe_r4: assert property (@(posedge clk) disable iff (!rst_s)
    ((plane_we & ~plane_en) == '0));
endmodule

// File: tb/sim_planar_write_path.sv
module sim_planar_write_path;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_sel, cpu_we;
  logic [7:0]  cfg_wdata, cfg_rdata, cpu_data;
  logic [31:0] latch_in, plane_data;
  logic [3:0]  plane_en, plane_we;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [3:0] sh_col, sh_cen;
  logic [7:0] sh_rfn, sh_mod, sh_msk;

  always #4 clk = ~clk;

  planar_write_path u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_we(cpu_we),
    .cpu_data(cpu_data), .latch_in(latch_in), .plane_en(plane_en),
    .plane_data(plane_data), .plane_we(plane_we)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    cfg_write(1'b0, idx);
    cfg_write(1'b1, d);
    case (idx[3:0])
      4'd0: sh_col = d[3:0];
      4'd1: sh_cen = d[3:0];
      4'd3: sh_rfn = d;
      4'd5: sh_mod = d;
      4'd8: sh_msk = d;
      default: ;
    endcase
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] v);
    cfg_write(1'b0, idx);
    cfg_sel = 1'b1;
    #1 v = cfg_rdata;
  endtask

  function automatic logic [7:0] b_ror(input logic [7:0] d, input int n);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[(i + n) % 8];
    return r;
  endfunction

  function automatic logic [31:0] b_model(input logic [7:0] cpu, input logic [31:0] lat);
    logic [31:0] o;
    logic [7:0]  r, s, a, l, m;
    r = b_ror(cpu, int'(sh_rfn[2:0]));
    for (int p = 0; p < 4; p++) begin
      l = lat[p*8 +: 8];
      if (sh_mod[1:0] == 2'd1) begin
        o[p*8 +: 8] = l;
      end else if (sh_mod[1:0] == 2'd3) begin
        m = r & sh_msk;
        o[p*8 +: 8] = (m & {8{sh_col[p]}}) | (l & ~m);
      end else begin
        if (sh_mod[1:0] == 2'd2) s = {8{cpu[p]}};
        else s = sh_cen[p] ? {8{sh_col[p]}} : r;
        case (sh_rfn[4:3])
          2'd1: a = s & l;
          2'd2: a = s | l;
          2'd3: a = s ^ l;
          default: a = s;
        endcase
        o[p*8 +: 8] = (a & sh_msk) | (l & ~sh_msk);
      end
    end
    return o;
  endfunction

  task automatic cpu_apply(input string tag, input logic we, input logic [7:0] d,
                           input logic [31:0] lat, input logic [3:0] en);
    @(negedge clk);
    cpu_we = we; cpu_data = d; latch_in = lat; plane_en = en;
    #1;
    check(tag, plane_data, b_model(d, lat));
    check("R4 strobe", {28'd0, plane_we}, {28'd0, en & {4{we}}});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    cpu_we = 1'b0; cpu_data = '0; latch_in = 32'hA5C3_3C5A; plane_en = '0;
    sh_col = '0; sh_cen = '0; sh_rfn = '0; sh_mod = '0; sh_msk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    #1 check("R11 index after reset", {24'd0, cfg_rdata}, 32'd0);
    check("R11 plane data after reset", plane_data, latch_in);
    foreach (sh_col[i]) ;
    for (int k = 0; k < 9; k++) begin
      reg_read(8'(k), v);
      check("R11 register after reset", {24'd0, v}, 32'd0);
    end

    // R1: index keeps low 4 bits
    cfg_write(1'b0, 8'hF3);
    cfg_sel = 1'b0;
    #1 check("R1 index truncation", {24'd0, cfg_rdata}, 32'h3);

    // R2: widths of stored registers
    reg_write(8'd0, 8'hFA); reg_write(8'd1, 8'h75); reg_write(8'd3, 8'hE9);
    reg_write(8'd5, 8'hC0); reg_write(8'd8, 8'h3C);
    reg_read(8'd0, v); check("R2 colour", {24'd0, v}, 32'h0A);
    reg_read(8'd1, v); check("R2 colour enable", {24'd0, v}, 32'h05);
    reg_read(8'd3, v); check("R2 rotate/function", {24'd0, v}, 32'hE9);
    reg_read(8'd5, v); check("R2 mode", {24'd0, v}, 32'hC0);
    reg_read(8'd8, v); check("R2 bit mask", {24'd0, v}, 32'h3C);

    // R3: unused indices read zero and ignore writes
    reg_write(8'd2, 8'hFF); reg_write(8'd9, 8'hFF); reg_write(8'd15, 8'hFF);
    reg_read(8'd2, v); check("R3 index 2 reads zero", {24'd0, v}, 32'd0);
    reg_read(8'd9, v); check("R3 index 9 reads zero", {24'd0, v}, 32'd0);
    reg_read(8'd0, v); check("R3 colour kept", {24'd0, v}, 32'h0A);
    reg_read(8'd3, v); check("R3 rotate kept", {24'd0, v}, 32'hE9);
    reg_read(8'd8, v); check("R3 mask kept", {24'd0, v}, 32'h3C);

    // R7/R10: directed logic functions with a partial mask, mode 0, no rotate
    reg_write(8'd1, 8'h00); reg_write(8'd5, 8'h00); reg_write(8'd8, 8'h0F);
    reg_write(8'd3, 8'h08);
    cpu_apply("R7 AND", 1'b1, 8'h3C, 32'hF0F0_FF00, 4'hF);
    check("R10 mask AND plane0", {24'd0, plane_data[7:0]}, 32'h00);
    reg_write(8'd3, 8'h10);
    cpu_apply("R7 OR", 1'b1, 8'h3C, 32'hF0F0_FF00, 4'hF);
    check("R10 mask OR plane0", {24'd0, plane_data[7:0]}, 32'h0C);
    reg_write(8'd3, 8'h18);
    cpu_apply("R7 XOR", 1'b1, 8'h3C, 32'hF0F0_FF00, 4'h5);
    check("R10 mask XOR plane1", {24'd0, plane_data[15:8]}, 32'hF3);

    // R6: rotate by 3 with colour substitution on plane 2
    reg_write(8'd3, 8'h03); reg_write(8'd8, 8'hFF);
    reg_write(8'd0, 8'h04); reg_write(8'd1, 8'h04);
    cpu_apply("R6 rotate", 1'b1, 8'h01, 32'h0, 4'hF);
    check("R6 rotated plane0", {24'd0, plane_data[7:0]}, 32'h20);
    check("R6 substituted plane2", {24'd0, plane_data[23:16]}, 32'hFF);

    // R8: fill mode
    reg_write(8'd5, 8'h02); reg_write(8'd3, 8'h00);
    cpu_apply("R8 fill", 1'b1, 8'h05, 32'h1234_5678, 4'hF);
    check("R8 fill exact", plane_data, 32'h00FF_00FF);

    // R9: pattern mode
    reg_write(8'd5, 8'h03); reg_write(8'd8, 8'hF0); reg_write(8'd0, 8'h09);
    cpu_apply("R9 pattern", 1'b1, 8'hCC, 32'h0000_0000, 4'hF);
    check("R9 pattern exact", plane_data, 32'hC000_00C0);

    // R5: copy mode
    reg_write(8'd5, 8'h01);
    cpu_apply("R5 copy", 1'b0, 8'hFF, 32'hDEAD_BEEF, 4'hA);

    // random mix
    for (int it = 0; it < 600; it++) begin
      if (($urandom % 3) == 0) begin
        int pick;
        logic [7:0] ix;
        pick = $urandom % 5;
        case (pick)
          0: ix = 8'd0; 1: ix = 8'd1; 2: ix = 8'd3; 3: ix = 8'd5;
          default: ix = 8'd8;
        endcase
        reg_write(ix, 8'($urandom));
      end
      case (sh_mod[1:0])
        2'd0: cpu_apply("R6 random mode 0", 1'($urandom), 8'($urandom), $urandom, 4'($urandom));
        2'd1: cpu_apply("R5 random mode 1", 1'($urandom), 8'($urandom), $urandom, 4'($urandom));
        2'd2: cpu_apply("R8 random mode 2", 1'($urandom), 8'($urandom), $urandom, 4'($urandom));
        default: cpu_apply("R9 random mode 3", 1'($urandom), 8'($urandom), $urandom, 4'($urandom));
      endcase
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule